// File: doc/BRIEF.md
# Console Command Byte Decoder

This block sits behind a processor I/O port and turns a byte stream into console actions. Each incoming byte carries a flag saying whether it is a control byte (an opcode) or a data byte. Opcodes select an action: some act at once (beep, carriage return, line feed, form feed), some wait for one argument byte (cursor column, cursor row, a single character), and some open a text stream that ends on a zero byte or after a count sent first. The block's only output is a one-cycle action strobe with a 3-bit action code and an 8-bit argument. A renderer downstream keeps the cursor and draws the text.

Bytes enter on a valid/ready interface. A byte moves only on a cycle where both `in_valid` and `in_ready` are high. The source must hold `in_byte` and `in_ctrl` steady while it waits. `in_ready` is high in every cycle except one: the cycle after a combined carriage-return/line-feed opcode is accepted, while the second strobe of that pair goes out. The action output has no back-pressure, so the consumer must take every strobe on the cycle it appears.

Top module: `con_cmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `act_valid` is 0, and the decoder is idle.
- R2: Control byte 1 makes the next data byte go out as one PUTC strobe with that byte as argument. Data bytes after it are ignored.
- R3: Control byte 2 makes each following data byte go out as a PUTC strobe until a data byte of 0 arrives. The 0 produces no strobe and returns the decoder to idle.
- R4: Control byte 3 takes the next data byte as a count N. The next N data bytes each go out as PUTC, and data bytes after them are ignored. N = 0 ends the operation with no strobe.
- R5: Control byte 4 sends the next data byte out as a SETX strobe. Control byte 5 sends it out as a SETY strobe.
- R6: Control bytes 7, 10, 11 and 12 each give one strobe with argument 0: BEEP, CR, FF and LF respectively.
- R7: Control byte 13 gives a CR strobe, then an LF strobe on the next cycle. `in_ready` is 0 during the cycle the CR strobe is shown.
- R8: A control byte with any value not listed in R2–R7 and R9 gives no strobe and returns the decoder to idle, so later data bytes are ignored.
- R9: A control byte that arrives while argument or text bytes are still expected ends the pending operation, and the new opcode is decoded. Control byte 0 only cancels and gives no strobe.
- R10: A strobe appears in the cycle after the byte that causes it is accepted, and it lasts exactly one cycle. A data byte received while idle gives no strobe. `act_code` values are PUTC=1, SETX=2, SETY=3, BEEP=4, CR=5, LF=6, FF=7.
- R11: A byte is consumed only on a cycle with both `in_valid` and `in_ready` high. A byte held while `in_ready` is low is taken on the first ready cycle and is decoded exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| in_ctrl | input | 1 | 1 = byte is an opcode, 0 = byte is data |
| in_byte | input | 8 | Input byte |
| act_valid | output | 1 | One-cycle action strobe |
| act_code | output | 3 | Action code (see R10) |
| act_arg | output | 8 | Action argument (character, column or row; 0 otherwise) |

## Verification
Text mode is driven with a zero-terminated run that has a byte after the terminator, so a missed stop or a printed zero shows up. A counted run gets one byte more than its count, and a second counted run has a count of zero, which separates off-by-one and zero-count faults. Opcodes are also sent in the middle of argument and text phases: a cancel, and a new cursor opcode straight after a cursor opcode. This shows whether a control byte really ends the pending work. The combined return/feed opcode is followed at once by another opcode, so a stall that drops, repeats or mis-times the held byte is seen in the strobe order.

// File: rtl/con_cmd_pkg.sv
package con_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;

  localparam logic [BYTE_W-1:0] OP_CLEAR = 8'd0;
  localparam logic [BYTE_W-1:0] OP_CHAR  = 8'd1;
  localparam logic [BYTE_W-1:0] OP_ZSTR  = 8'd2;
  localparam logic [BYTE_W-1:0] OP_NSTR  = 8'd3;
  localparam logic [BYTE_W-1:0] OP_COL   = 8'd4;
  localparam logic [BYTE_W-1:0] OP_ROW   = 8'd5;
  localparam logic [BYTE_W-1:0] OP_BEEP  = 8'd7;
  localparam logic [BYTE_W-1:0] OP_CR    = 8'd10;
  localparam logic [BYTE_W-1:0] OP_FF    = 8'd11;
  localparam logic [BYTE_W-1:0] OP_LF    = 8'd12;
  localparam logic [BYTE_W-1:0] OP_CRLF  = 8'd13;

  typedef enum logic [CODE_W-1:0] {
    ACT_NONE = 3'd0,
    ACT_PUTC = 3'd1,
    ACT_SETX = 3'd2,
    ACT_SETY = 3'd3,
    ACT_BEEP = 3'd4,
    ACT_CR   = 3'd5,
    ACT_LF   = 3'd6,
    ACT_FF   = 3'd7
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ONE  = 3'd1,
    ST_ZSTR = 3'd2,
    ST_CNT  = 3'd3,
    ST_NSTR = 3'd4,
    ST_XARG = 3'd5,
    ST_YARG = 3'd6
  } st_e;
endpackage

// File: rtl/con_op_decode.sv
module con_op_decode
  import con_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output st_e               nxt_st,
  output logic              emit,
  output act_e              code,
  output logic              crlf
);
  always_comb begin
    nxt_st = ST_IDLE;
    emit   = 1'b0;
    code   = ACT_NONE;
    crlf   = 1'b0;
    case (opcode)
      OP_CLEAR: nxt_st = ST_IDLE;
      OP_CHAR:  nxt_st = ST_ONE;
      OP_ZSTR:  nxt_st = ST_ZSTR;
      OP_NSTR:  nxt_st = ST_CNT;
      OP_COL:   nxt_st = ST_XARG;
      OP_ROW:   nxt_st = ST_YARG;
      OP_BEEP:  begin emit = 1'b1; code = ACT_BEEP; end
      OP_CR:    begin emit = 1'b1; code = ACT_CR;   end
      OP_FF:    begin emit = 1'b1; code = ACT_FF;   end
      OP_LF:    begin emit = 1'b1; code = ACT_LF;   end
      OP_CRLF:  begin emit = 1'b1; code = ACT_CR; crlf = 1'b1; end
      default:  nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/con_len_counter.sv
module con_len_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end

  assign last = (rem_q == {{(W-1){1'b0}}, 1'b1});

  // R4: a counted character never arrives with nothing left to count
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0));
endmodule

// File: rtl/con_act_out.sv
module con_act_out
  import con_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  act_e              code,
  input  logic [BYTE_W-1:0] arg,
  input  logic              crlf,
  output logic              act_valid,
  output act_e              act_code,
  output logic [BYTE_W-1:0] act_arg,
  output logic              lf_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_code  <= ACT_NONE;
      act_arg   <= '0;
      lf_pend   <= 1'b0;
    end else if (lf_pend) begin
      act_valid <= 1'b1;
      act_code  <= ACT_LF;
      act_arg   <= '0;
      lf_pend   <= 1'b0;
    end else begin
      act_valid <= emit;
      act_code  <= emit ? code : ACT_NONE;
      act_arg   <= emit ? arg : '0;
      lf_pend   <= emit & crlf;
    end
  end

  // R7: while the second half is pending, the first half is on the output
  p_cr_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lf_pend |-> (act_valid && act_code == ACT_CR));
  // R7: the line feed follows on the very next cycle
  p_lf_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lf_pend |=> (act_valid && act_code == ACT_LF));
  // R10: a strobe always carries a real action code
  p_code_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_code != ACT_NONE));
endmodule

// File: rtl/con_cmd_decoder.sv
module con_cmd_decoder
  import con_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ctrl,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              act_valid,
  output logic [CODE_W-1:0] act_code,
  output logic [BYTE_W-1:0] act_arg
);
  st_e               st_q, st_n, dec_st;
  logic              dec_emit, dec_crlf;
  act_e              dec_code;
  logic              emit, crlf, cnt_load, cnt_dec, cnt_last, lf_pend;
  act_e              code, out_code;
  logic [BYTE_W-1:0] arg;
  logic              accept;

  assign in_ready = ~lf_pend;
  assign accept   = in_valid & in_ready;

  con_op_decode u_dec (
    .opcode (in_byte),
    .nxt_st (dec_st),
    .emit   (dec_emit),
    .code   (dec_code),
    .crlf   (dec_crlf)
  );

  con_len_counter #(.W(BYTE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (in_byte),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  always_comb begin
    st_n     = st_q;
    emit     = 1'b0;
    code     = ACT_NONE;
    arg      = '0;
    crlf     = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (accept) begin
      if (in_ctrl) begin
        st_n = dec_st;
        emit = dec_emit;
        code = dec_code;
        crlf = dec_crlf;
      end else begin
        case (st_q)
          ST_IDLE: st_n = ST_IDLE;
          ST_ONE: begin
            emit = 1'b1; code = ACT_PUTC; arg = in_byte; st_n = ST_IDLE;
          end
          ST_ZSTR: begin
            if (in_byte == '0) st_n = ST_IDLE;
            else begin emit = 1'b1; code = ACT_PUTC; arg = in_byte; end
          end
          ST_CNT: begin
            if (in_byte == '0) st_n = ST_IDLE;
            else begin cnt_load = 1'b1; st_n = ST_NSTR; end
          end
          ST_NSTR: begin
            emit = 1'b1; code = ACT_PUTC; arg = in_byte; cnt_dec = 1'b1;
            if (cnt_last) st_n = ST_IDLE;
          end
          ST_XARG: begin
            emit = 1'b1; code = ACT_SETX; arg = in_byte; st_n = ST_IDLE;
          end
          ST_YARG: begin
            emit = 1'b1; code = ACT_SETY; arg = in_byte; st_n = ST_IDLE;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  con_act_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .code      (code),
    .arg       (arg),
    .crlf      (crlf),
    .act_valid (act_valid),
    .act_code  (out_code),
    .act_arg   (act_arg),
    .lf_pend   (lf_pend)
  );
  assign act_code = out_code;

  // R10: every strobe is caused by an accepted byte or a pending line feed
  p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> ($past(accept) || $past(lf_pend)));
  // R10: a data byte while idle produces nothing
  p_idle_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_ctrl && st_q == ST_IDLE) |=> !act_valid);
  // R3: the terminating zero is never printed
  p_zero_not_printed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_ctrl && st_q == ST_ZSTR && in_byte == '0) |=> !act_valid);
  // R6: fixed actions carry a zero argument
  p_fixed_arg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (act_code == ACT_BEEP || act_code == ACT_CR ||
                   act_code == ACT_LF   || act_code == ACT_FF)) |-> (act_arg == '0));
  // R11: nothing is taken while stalled, and the stall lasts one cycle
  p_stall_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
endmodule

// File: tb/tb_con_cmd_decoder.sv
module tb_con_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_ctrl = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic       act_valid;
  logic [2:0] act_code;
  logic [7:0] act_arg;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [2:0] C_PUTC = 3'd1, C_SETX = 3'd2, C_SETY = 3'd3,
                         C_BEEP = 3'd4, C_CR = 3'd5, C_LF = 3'd6, C_FF = 3'd7;

  logic [10:0] got[$];
  logic [10:0] exp[$];

  always #5 clk = ~clk;

  con_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_byte(in_byte), .act_valid(act_valid),
    .act_code(act_code), .act_arg(act_arg)
  );

  always @(negedge clk)
    if (rst_n && act_valid) got.push_back({act_code, act_arg});

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, want);
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic c, input logic [7:0] b);
    in_valid = 1'b1; in_ctrl = c; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic want(input logic [2:0] c, input logic [7:0] a);
    exp.push_back({c, a});
  endtask

  task automatic compare(input string req);
    repeat (3) @(negedge clk);
    check({req, " count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size(); i++) begin
      if (i < got.size()) check({req, " strobe"}, got[i], exp[i]);
    end
    got.delete(); exp.delete();
  endtask

  task automatic t_reset;
    check("R1 ready", in_ready, 1'b1);
    check("R1 valid", act_valid, 1'b0);
    send(1'b0, 8'h41);
    compare("R1/R10 idle data ignored");
  endtask

  task automatic t_single;
    send(1'b1, 8'd1); send(1'b0, 8'h48); send(1'b0, 8'h49);
    want(C_PUTC, 8'h48);
    compare("R2 single char");
  endtask

  task automatic t_timing;
    send(1'b1, 8'd1); send(1'b0, 8'h5A);
    check("R10 strobe next cycle", {act_valid, act_code, act_arg}, {1'b1, C_PUTC, 8'h5A});
    @(negedge clk);
    check("R10 strobe one cycle", act_valid, 1'b0);
    got.delete();
  endtask

  task automatic t_zstr;
    send(1'b1, 8'd2);
    send(1'b0, 8'h41); send(1'b0, 8'h42); send(1'b0, 8'h00); send(1'b0, 8'h43);
    want(C_PUTC, 8'h41); want(C_PUTC, 8'h42);
    compare("R3 zero-terminated");
  endtask

  task automatic t_count;
    send(1'b1, 8'd3); send(1'b0, 8'd3);
    send(1'b0, 8'h61); send(1'b0, 8'h62); send(1'b0, 8'h63); send(1'b0, 8'h64);
    want(C_PUTC, 8'h61); want(C_PUTC, 8'h62); want(C_PUTC, 8'h63);
    compare("R4 counted");
    send(1'b1, 8'd3); send(1'b0, 8'd0); send(1'b0, 8'h55);
    compare("R4 zero count");
  endtask

  task automatic t_cursor;
    send(1'b1, 8'd4); send(1'b0, 8'd17);
    send(1'b1, 8'd5); send(1'b0, 8'd9);
    want(C_SETX, 8'd17); want(C_SETY, 8'd9);
    compare("R5 cursor");
  endtask

  task automatic t_fixed;
    send(1'b1, 8'd7); send(1'b1, 8'd10); send(1'b1, 8'd11); send(1'b1, 8'd12);
    want(C_BEEP, 8'd0); want(C_CR, 8'd0); want(C_FF, 8'd0); want(C_LF, 8'd0);
    compare("R6 fixed actions");
  endtask

  task automatic t_crlf;
    send(1'b1, 8'd13);
    check("R7 ready low", in_ready, 1'b0);
    check("R7 CR first", {act_valid, act_code}, {1'b1, C_CR});
    send(1'b1, 8'd7);
    want(C_CR, 8'd0); want(C_LF, 8'd0); want(C_BEEP, 8'd0);
    compare("R7/R11 crlf then held byte");
  endtask

  task automatic t_unknown;
    send(1'b1, 8'd6); send(1'b0, 8'h33);
    send(1'b1, 8'd200); send(1'b0, 8'h34);
    compare("R8 unknown opcode");
  endtask

  task automatic t_abort;
    send(1'b1, 8'd3); send(1'b0, 8'd5); send(1'b0, 8'h61);
    send(1'b1, 8'd0); send(1'b0, 8'h62);
    want(C_PUTC, 8'h61);
    compare("R9 cancel count");
    send(1'b1, 8'd2); send(1'b0, 8'h70); send(1'b1, 8'd4); send(1'b0, 8'h20);
    want(C_PUTC, 8'h70); want(C_SETX, 8'h20);
    compare("R9 text then column");
    send(1'b1, 8'd4); send(1'b1, 8'd5); send(1'b0, 8'd8);
    want(C_SETY, 8'd8);
    compare("R9 column then row");
  endtask

  task automatic t_hold;
    // R11: a byte offered with in_valid low is never taken
    in_ctrl = 1'b1; in_byte = 8'd7; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11 no valid no action");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_single; t_timing; t_zstr; t_count; t_cursor;
    t_fixed; t_crlf; t_unknown; t_abort; t_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule